// File: doc/BRIEF.md
# Quick-Channel Trigger and Completion Controller

This block sits beside a DMA transfer engine and turns ordinary parameter-set writes into start events. Each of eight quick channels is pointed at one parameter set and at one word inside that set. A snoop port reports every write that lands in parameter storage. When the write matches an enabled channel's set and word, the block raises an event toward the engine over a valid/ready handshake. Software can therefore launch a transfer simply by writing the last field it needs to fill in.

The block keeps an outstanding-event bit and a missed-event bit for each channel. It also keeps 64 completion-pending bits, set by codes that the engine reports when a transfer finishes. Software polls those bits and clears them by writing ones. All state is visible through a small register bus that reads without wait states.

Register offsets (byte addresses, 32-bit words):

| Offset | Access | Content |
|---|---|---|
| 0x00 + 4·ch | read/write | channel map |
| 0x20 | read | enable |
| 0x24 | write-ones-set | enable |
| 0x28 | write-ones-clear | enable |
| 0x30 | read | outstanding event |
| 0x34 | write-ones-clear | outstanding event |
| 0x38 | read | missed event |
| 0x3C | write-ones-clear | missed event |
| 0x40 / 0x44 | read | completion pending, codes 0–31 / 32–63 |
| 0x48 / 0x4C | write-ones-clear | completion pending, codes 0–31 / 32–63 |

Top module: `qtc_ctrl`

## Requirements
- R1: After reset every map, enable, outstanding, missed and pending bit reads 0, and evt_valid is 0.
- R2: A write to a channel map at 0x00+4·ch stores wdata[13:5] as the parameter set and wdata[4:2] as the trigger word. A read returns them in those positions, and all other bits read 0.
- R3: Writing ones at 0x24 sets enable bits, and writing ones at 0x28 clears them. Zero bits have no effect, and a write to the read-only enable view at 0x20 changes nothing.
- R4: A snoop write whose set and word match an enabled channel's map sets that channel's outstanding bit (bit ch of 0x30) at the next clock edge. evt_valid then rises with evt_chan = ch and evt_set = the mapped set. A disabled or non-matching snoop raises nothing.
- R5: While evt_valid is high and evt_ready is low, evt_valid stays high and evt_chan does not change, even when a lower-numbered channel triggers. An accepted event (valid and ready at a clock edge) clears that channel's outstanding bit.
- R6: When several outstanding bits are set and no event is being held, the lowest-numbered channel is presented first.
- R7: A trigger for a channel whose outstanding bit is set and is not accepted in the same cycle sets its missed bit (bit ch of 0x38) and raises no second event. A trigger in the same cycle as that channel's acceptance raises a new event and no miss.
- R8: Writing ones at 0x34 clears outstanding bits except for the channel currently presented on the event port. Writing ones at 0x3C clears missed bits.
- R9: A completion with code c sets bit c of 0x40 when c < 32, and bit c−32 of 0x44 otherwise.
- R10: Writing ones at 0x48 or 0x4C clears the matching pending bits. A completion that sets a bit in the same cycle as its clear leaves it set.
- R11: A read of an unmapped address returns 0, and a write there changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | register write strobe |
| bus_addr | input | 8 | register byte address |
| bus_wdata | input | 32 | register write data |
| bus_rdata | output | 32 | register read data for bus_addr, same cycle |
| ps_wr | input | 1 | snoop: a parameter-set word is being written |
| ps_set | input | 9 | snoop: parameter set number of that write |
| ps_word | input | 3 | snoop: word index within the set |
| evt_valid | output | 1 | start event pending toward the engine |
| evt_ready | input | 1 | engine accepts the event |
| evt_chan | output | 3 | channel of the presented event |
| evt_set | output | 9 | parameter set mapped to that channel |
| cmp_valid | input | 1 | completion report strobe |
| cmp_code | input | 6 | completion code |

## Verification
The hardest situations to reach are those where a new trigger collides with an event already in flight. One case is a trigger landing in the exact cycle its own channel is accepted. Another is a lower channel triggering while a higher one is held, and a third is a software clear aimed at the presented channel. The bench reaches these by holding evt_ready low to freeze an event. It then drives the snoop strobe, the ready line and the clear write on one chosen falling edge, so that all three meet at the same rising edge. The pending set-versus-clear race is reached the same way, with the completion strobe and the clear write driven together.

// File: rtl/qtc_pkg.sv
package qtc_pkg;

  localparam int SET_W    = 9;
  localparam int WORD_W   = 3;
  localparam int SET_LSB  = 5;
  localparam int WORD_LSB = 2;

  // register byte offsets
  localparam int OFF_MAP       = 'h00;
  localparam int OFF_EN_STAT   = 'h20;
  localparam int OFF_EN_SET    = 'h24;
  localparam int OFF_EN_CLR    = 'h28;
  localparam int OFF_SEC_STAT  = 'h30;
  localparam int OFF_SEC_CLR   = 'h34;
  localparam int OFF_MISS_STAT = 'h38;
  localparam int OFF_MISS_CLR  = 'h3C;
  localparam int OFF_PEND      = 'h40;
  localparam int OFF_PEND_CLR  = 'h48;

  typedef struct packed {
    logic [SET_W-1:0]  set;
    logic [WORD_W-1:0] word;
  } map_t;

endpackage

// File: rtl/qtc_chan_cfg.sv
module qtc_chan_cfg
  import qtc_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      map_we,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NCH-1:0]      en_set,
  input  logic [NCH-1:0]      en_clr,
  output map_t [NCH-1:0]      map_q,
  output logic [NCH-1:0]      en_q
);

  map_t [NCH-1:0] map_d;
  logic [NCH-1:0] en_d;
  logic           map_ce;
  logic           en_ce;

  always_comb begin
    map_d = map_q;
    for (int c = 0; c < NCH; c++) begin
      if (map_we[c]) begin
        map_d[c].set  = wdata[SET_LSB +: SET_W];
        map_d[c].word = wdata[WORD_LSB +: WORD_W];
      end
    end
    en_d   = (en_q | en_set) & ~en_clr;
    map_ce = |map_we;
    en_ce  = |(en_set | en_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      en_q  <= '0;
    end else begin
      if (map_ce) map_q <= map_d;
      if (en_ce)  en_q  <= en_d;
    end
  end

endmodule

// File: rtl/qtc_trig_match.sv
module qtc_trig_match
  import qtc_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                ps_wr,
  input  logic [SET_W-1:0]    ps_set,
  input  logic [WORD_W-1:0]   ps_word,
  input  map_t [NCH-1:0]      map_q,
  input  logic [NCH-1:0]      en_q,
  output logic [NCH-1:0]      trig
);

  for (genvar g = 0; g < NCH; g++) begin : g_cmp
    assign trig[g] = ps_wr && en_q[g]
                     && (map_q[g].set  == ps_set)
                     && (map_q[g].word == ps_word);
  end

endmodule

// File: rtl/qtc_evt_arb.sv
module qtc_evt_arb #(
  parameter int NCH  = 8,
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  trig,
  input  logic [NCH-1:0]  sec_clr,
  input  logic [NCH-1:0]  miss_clr,
  input  logic            evt_ready,
  output logic            evt_valid,
  output logic [CH_W-1:0] evt_chan,
  output logic [NCH-1:0]  sec_q,
  output logic [NCH-1:0]  miss_q
);

  logic [NCH-1:0]  sec_d;
  logic [NCH-1:0]  miss_d;
  logic            hold_q;
  logic            hold_d;
  logic [CH_W-1:0] hold_ch_q;
  logic [CH_W-1:0] lo_ch;
  logic [NCH-1:0]  pres;
  logic [NCH-1:0]  acc;

  // lowest-numbered outstanding channel
  always_comb begin
    lo_ch = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (sec_q[i]) lo_ch = CH_W'(i);
    end
  end

  assign evt_valid = |sec_q;
  assign evt_chan  = hold_q ? hold_ch_q : lo_ch;

  always_comb begin
    pres   = evt_valid ? (NCH'(1) << evt_chan) : '0;
    acc    = evt_ready ? pres : '0;
    // presented channel is shielded from software clear; trigger wins
    sec_d  = (sec_q & ~acc & ~(sec_clr & ~pres)) | trig;
    miss_d = (miss_q & ~miss_clr) | (trig & sec_q & ~acc);
    hold_d = evt_valid && !evt_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q     <= '0;
      miss_q    <= '0;
      hold_q    <= 1'b0;
      hold_ch_q <= '0;
    end else begin
      sec_q  <= sec_d;
      miss_q <= miss_d;
      hold_q <= hold_d;
      if (hold_d) hold_ch_q <= evt_chan;
    end
  end

endmodule

// File: rtl/qtc_pend.sv
module qtc_pend #(
  parameter int CODE_W = 6,
  parameter int NPEND  = 1 << CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [CODE_W-1:0] cmp_code,
  input  logic [NPEND-1:0]  clr,
  output logic [NPEND-1:0]  pend_q
);

  logic [NPEND-1:0] set_vec;
  logic [NPEND-1:0] pend_d;
  logic             pend_ce;

  always_comb begin
    set_vec = {{(NPEND-1){1'b0}}, cmp_valid} << cmp_code;
    pend_d  = (pend_q & ~clr) | set_vec;
    pend_ce = cmp_valid || (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/qtc_ctrl.sv
module qtc_ctrl
  import qtc_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CODE_W = 6,
  localparam int CH_W   = $clog2(NCH),
  localparam int NPEND  = 1 << CODE_W,
  localparam int NPWORD = NPEND / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ps_wr,
  input  logic [SET_W-1:0]  ps_set,
  input  logic [WORD_W-1:0] ps_word,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [CH_W-1:0]   evt_chan,
  output logic [SET_W-1:0]  evt_set,
  input  logic              cmp_valid,
  input  logic [CODE_W-1:0] cmp_code
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // write decode
  logic [NCH-1:0]   map_we;
  logic [NCH-1:0]   en_set;
  logic [NCH-1:0]   en_clr;
  logic [NCH-1:0]   sec_clr;
  logic [NCH-1:0]   miss_clr;
  logic [NPEND-1:0] pend_clr;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      map_we[c] = bus_wr && (bus_addr == ADDR_W'(OFF_MAP + 4 * c));
    end
    en_set   = (bus_wr && bus_addr == ADDR_W'(OFF_EN_SET))   ? bus_wdata[NCH-1:0] : '0;
    en_clr   = (bus_wr && bus_addr == ADDR_W'(OFF_EN_CLR))   ? bus_wdata[NCH-1:0] : '0;
    sec_clr  = (bus_wr && bus_addr == ADDR_W'(OFF_SEC_CLR))  ? bus_wdata[NCH-1:0] : '0;
    miss_clr = (bus_wr && bus_addr == ADDR_W'(OFF_MISS_CLR)) ? bus_wdata[NCH-1:0] : '0;
    for (int w = 0; w < NPWORD; w++) begin
      pend_clr[w*DATA_W +: DATA_W] =
        (bus_wr && bus_addr == ADDR_W'(OFF_PEND_CLR + 4 * w)) ? bus_wdata : '0;
    end
  end

  map_t [NCH-1:0]   map_q;
  logic [NCH-1:0]   en_q;
  logic [NCH-1:0]   trig;
  logic [NCH-1:0]   sec_q;
  logic [NCH-1:0]   miss_q;
  logic [NPEND-1:0] pend_q;

  qtc_chan_cfg #(.NCH(NCH), .DATA_W(DATA_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_ni),
    .map_we (map_we),
    .wdata  (bus_wdata),
    .en_set (en_set),
    .en_clr (en_clr),
    .map_q  (map_q),
    .en_q   (en_q)
  );

  qtc_trig_match #(.NCH(NCH)) u_match (
    .ps_wr   (ps_wr),
    .ps_set  (ps_set),
    .ps_word (ps_word),
    .map_q   (map_q),
    .en_q    (en_q),
    .trig    (trig)
  );

  qtc_evt_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_ni),
    .trig      (trig),
    .sec_clr   (sec_clr),
    .miss_clr  (miss_clr),
    .evt_ready (evt_ready),
    .evt_valid (evt_valid),
    .evt_chan  (evt_chan),
    .sec_q     (sec_q),
    .miss_q    (miss_q)
  );

  qtc_pend #(.CODE_W(CODE_W), .NPEND(NPEND)) u_pend (
    .clk       (clk),
    .rst_n     (rst_ni),
    .cmp_valid (cmp_valid),
    .cmp_code  (cmp_code),
    .clr       (pend_clr),
    .pend_q    (pend_q)
  );

  assign evt_set = map_q[evt_chan].set;

  // read mux
  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(OFF_MAP + 4 * c)) begin
        bus_rdata[SET_LSB +: SET_W]   = map_q[c].set;
        bus_rdata[WORD_LSB +: WORD_W] = map_q[c].word;
      end
    end
    if (bus_addr == ADDR_W'(OFF_EN_STAT))   bus_rdata[NCH-1:0] = en_q;
    if (bus_addr == ADDR_W'(OFF_SEC_STAT))  bus_rdata[NCH-1:0] = sec_q;
    if (bus_addr == ADDR_W'(OFF_MISS_STAT)) bus_rdata[NCH-1:0] = miss_q;
    for (int w = 0; w < NPWORD; w++) begin
      if (bus_addr == ADDR_W'(OFF_PEND + 4 * w)) bus_rdata = pend_q[w*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/qtc_ctrl_chk.sv
module qtc_ctrl_chk
  import qtc_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CH_W   = 3,
  parameter int ADDR_W = 8,
  parameter int CODE_W = 6,
  parameter int NPEND  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NCH-1:0]    wdata_lo,
  input logic              evt_valid,
  input logic              evt_ready,
  input logic [CH_W-1:0]   evt_chan,
  input logic              cmp_valid,
  input logic [CODE_W-1:0] cmp_code,
  input logic [NCH-1:0]    sec_q,
  input logic [NCH-1:0]    en_q,
  input logic [NPEND-1:0]  pend_q
);

  logic [NCH-1:0] low_mask;
  assign low_mask = (NCH'(1) << evt_chan) - NCH'(1);

  // R5
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_ready |=> evt_valid && $stable(evt_chan));

  // R4
  evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> sec_q[evt_chan]);

  // R6
  evt_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !$past(evt_valid && !evt_ready) |-> (sec_q & low_mask) == '0);

  // R10
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |=> pend_q[$past(cmp_code)]);

  // R3
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == ADDR_W'(OFF_EN_SET) |=> (en_q & $past(wdata_lo)) == $past(wdata_lo));

endmodule

bind qtc_ctrl qtc_ctrl_chk #(
  .NCH(NCH), .CH_W(CH_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W), .NPEND(NPEND)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_ni),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .wdata_lo  (bus_wdata[NCH-1:0]),
  .evt_valid (evt_valid),
  .evt_ready (evt_ready),
  .evt_chan  (evt_chan),
  .cmp_valid (cmp_valid),
  .cmp_code  (cmp_code),
  .sec_q     (sec_q),
  .en_q      (en_q),
  .pend_q    (pend_q)
);

// File: tb/sim_qtc_ctrl.sv
module sim_qtc_ctrl;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ps_wr;
  logic [8:0]  ps_set;
  logic [2:0]  ps_word;
  logic        evt_valid;
  logic        evt_ready;
  logic [2:0]  evt_chan;
  logic [8:0]  evt_set;
  logic        cmp_valid;
  logic [5:0]  cmp_code;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  qtc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ps_wr(ps_wr),
    .ps_set(ps_set), .ps_word(ps_word), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_chan(evt_chan), .evt_set(evt_set),
    .cmp_valid(cmp_valid), .cmp_code(cmp_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // {req[3:0], waddr[7:0], wdata[31:0], raddr[7:0], exp[31:0]}
  localparam int NVEC = 9;
  localparam logic [83:0] VEC [0:NVEC-1] = '{
    {4'd2,  8'h00, 32'hFFFF_FFFF, 8'h00, 32'h0000_3FFC}, // R2 field mask
    {4'd2,  8'h0C, 32'h0000_00BC, 8'h0C, 32'h0000_00BC}, // R2 ch3 set 5 word 7
    {4'd11, 8'h80, 32'hFFFF_FFFF, 8'h04, 32'h0000_0000}, // R11 write ignored
    {4'd11, 8'h84, 32'h0000_0000, 8'h80, 32'h0000_0000}, // R11 read zero
    {4'd3,  8'h24, 32'h0000_0009, 8'h20, 32'h0000_0009}, // R3 set
    {4'd3,  8'h24, 32'h0000_0000, 8'h20, 32'h0000_0009}, // R3 zeros no effect
    {4'd3,  8'h28, 32'h0000_0001, 8'h20, 32'h0000_0008}, // R3 clear
    {4'd3,  8'h20, 32'h0000_00FF, 8'h20, 32'h0000_0008}, // R3 status read-only
    {4'd2,  8'h00, 32'h0000_0003, 8'h00, 32'h0000_0000}  // R2 low bits dropped
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic snoop(input logic [8:0] s, input logic [2:0] w);
    @(negedge clk);
    ps_wr = 1'b1; ps_set = s; ps_word = w;
    @(negedge clk);
    ps_wr = 1'b0;
  endtask

  task automatic cmp(input logic [5:0] c);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_code = c;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic accept();
    evt_ready = 1'b1;
    step();
    evt_ready = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    ps_wr = 1'b0; ps_set = '0; ps_word = '0; evt_ready = 1'b0;
    cmp_valid = 1'b0; cmp_code = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    chk("R1 evt_valid", 32'(evt_valid), 0);
    rd(8'h00, r); chk("R1 map0", r, 0);
    rd(8'h20, r); chk("R1 enable", r, 0);
    rd(8'h30, r); chk("R1 outstanding", r, 0);
    rd(8'h38, r); chk("R1 missed", r, 0);
    rd(8'h40, r); chk("R1 pend lo", r, 0);
    rd(8'h44, r); chk("R1 pend hi", r, 0);

    // register vectors
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][79:72], VEC[i][71:40]);
      rd(VEC[i][39:32], r);
      n_chk++;
      if (r !== VEC[i][31:0]) begin
        n_err++;
        $display("FAIL R%0d vector %0d: act=%h exp=%h", VEC[i][83:80], i, r, VEC[i][31:0]);
      end
    end

    // R4 trigger: en=0x08, ch3 -> set 5 word 7, ch0 -> set 0 word 0 disabled
    snoop(9'd5, 3'd6);
    chk("R4 wrong word", 32'(evt_valid), 0);
    snoop(9'd0, 3'd0);
    chk("R4 disabled channel", 32'(evt_valid), 0);
    rd(8'h30, r); chk("R4 no outstanding", r, 0);
    snoop(9'd5, 3'd7);
    chk("R4 valid", 32'(evt_valid), 1);
    chk("R4 chan", 32'(evt_chan), 3);
    chk("R4 set", 32'(evt_set), 5);
    rd(8'h30, r); chk("R4 outstanding", r, 32'h08);

    // R5 hold then accept
    repeat (3) step();
    chk("R5 held valid", 32'(evt_valid), 1);
    chk("R5 held chan", 32'(evt_chan), 3);
    accept();
    chk("R5 accepted", 32'(evt_valid), 0);
    rd(8'h30, r); chk("R5 outstanding cleared", r, 0);

    // R7 retrigger while outstanding
    snoop(9'd5, 3'd7);
    snoop(9'd5, 3'd7);
    rd(8'h38, r); chk("R7 missed set", r, 32'h08);
    rd(8'h30, r); chk("R7 outstanding", r, 32'h08);
    accept();
    chk("R7 no second event", 32'(evt_valid), 0);
    wr(8'h3C, 32'h08);
    rd(8'h38, r); chk("R8 missed cleared", r, 0);

    // R7 trigger in the cycle of acceptance
    snoop(9'd5, 3'd7);
    @(negedge clk);
    ps_wr = 1'b1; ps_set = 9'd5; ps_word = 3'd7; evt_ready = 1'b1;
    @(negedge clk);
    ps_wr = 1'b0; evt_ready = 1'b0;
    chk("R7 new event", 32'(evt_valid), 1);
    rd(8'h38, r); chk("R7 no miss on accept", r, 0);
    accept();
    chk("R7 drained", 32'(evt_valid), 0);

    // R6 lowest first
    wr(8'h04, 32'h0000_0404);   // ch1 -> set 0x20 word 1
    wr(8'h18, 32'h0000_0404);   // ch6 -> set 0x20 word 1
    wr(8'h24, 32'h0000_0042);
    snoop(9'h20, 3'd1);
    chk("R6 lowest first", 32'(evt_chan), 1);
    rd(8'h30, r); chk("R6 both outstanding", r, 32'h42);
    accept();
    chk("R6 next valid", 32'(evt_valid), 1);
    chk("R6 next chan", 32'(evt_chan), 6);
    accept();
    chk("R6 drained", 32'(evt_valid), 0);

    // R5 lower trigger while held, R8 protected clear
    wr(8'h18, 32'h0000_0604);   // ch6 -> set 0x30 word 1
    snoop(9'h30, 3'd1);
    chk("R5 ch6 presented", 32'(evt_chan), 6);
    snoop(9'h20, 3'd1);
    chk("R5 held over lower", 32'(evt_chan), 6);
    wr(8'h34, 32'h42);
    rd(8'h30, r); chk("R8 presented kept", r, 32'h40);
    chk("R8 still valid", 32'(evt_valid), 1);
    accept();
    chk("R8 drained", 32'(evt_valid), 0);

    // R9 completions
    cmp(6'd3);
    cmp(6'd40);
    cmp(6'd63);
    rd(8'h40, r); chk("R9 low word", r, 32'h0000_0008);
    rd(8'h44, r); chk("R9 high word", r, 32'h8000_0100);

    // R10 clears and set-wins
    wr(8'h48, 32'h08);
    rd(8'h40, r); chk("R10 low cleared", r, 0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h4C; bus_wdata = 32'h100;
    cmp_valid = 1'b1; cmp_code = 6'd40;
    @(negedge clk);
    bus_wr = 1'b0; cmp_valid = 1'b0;
    rd(8'h44, r); chk("R10 set wins", r, 32'h8000_0100);
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h44, r); chk("R10 high cleared", r, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule